// File: doc/BRIEF.md
# Corrected Logarithmic Approximate Multiplier

This block forms an approximate product of two unsigned integers in the logarithmic domain. Each operand is turned into a piecewise-linear base-2 logarithm. The integer part (the characteristic) is the position of the operand's most significant one. The bits below that one become the binary fraction. The two logarithms are added. The result is then raised back to a linear value with a shift.

The piecewise-linear logarithm always reads low, so the plain shift-based product reads low as well. A correction term is added to the log sum before the conversion back. The term comes from a 64-entry constant table, indexed by the three leading fraction bits of each operand. Each entry is the error of the plain method averaged over its pair of fraction ranges. The table is computed at elaboration from a closed formula, so no constants are typed in.

If either operand is zero, the output is zero. The output is registered one cycle after the operands are sampled. It saturates to all ones when the conversion back would exceed the output width.

Top module: `mitch_log_mult`

## Requirements
- R1: While `rst_ni` is low, `prod_o` is 0. Reset is asynchronous and takes effect without waiting for a clock edge.
- R2: `prod_o` holds the result for the operands sampled at the previous rising edge of `clk_i`. The latency is exactly one cycle.
- R3: If `op_a_i` or `op_b_i` is zero, `prod_o` is 0 one cycle later.
- R4: For a nonzero operand, the characteristic k is the bit index of its most significant one. The fraction x is the k bits below that one, left-aligned into a 15-bit field of weight 2^-15, so 0 <= x < 1. For example, 25 gives k = 4 and x = 0.5625.
- R5: Let i be the top 3 bits of the fraction of `op_a_i` and j the top 3 bits of the fraction of `op_b_i`. Let a = 17 + 2i, b = 17 + 2j and q = a*b. The correction is c = (q < 512 ? 2q - 512 : q) - 64(i + j + 1), in units of 2^-9. Example: i = j = 0 gives c = 2. Example: i = j = 4 gives c = 49.
- R6: The log sum is L = k_a + k_b + x_a + x_b + c. With I the integer part of L and F its 15-bit fraction, the result is floor((1 + F) * 2^I). Example: 3 x 3 gives 8. Example: 32768 x 32768 gives 0x40400000.
- R7: If I >= 32, `prod_o` saturates to 0xFFFFFFFF. Example: 0xFFFF x 0xFFFF saturates.
- R8: When both operands are at least 256, the relative error against the exact product is below 6%. Over a random operand set, the mean relative error is below that of the same method without correction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 16 | First unsigned operand |
| op_b_i | input | 16 | Second unsigned operand |
| prod_o | output | 32 | Registered approximate product |

## Verification
The block is driven with random operands of random bit length, which spread the characteristics and all 64 table cells. Every output is compared bit for bit against an independent model of the log, correction and shift steps. Directed cases separate the individual mechanisms:
- Zero operands check the bypass.
- Powers of two check the zero-fraction corner, where only the corner correction entry acts.
- 3 x 3 and 25 x 1 check the fraction extraction and truncation.
- Full-scale operands check the saturation.

For large operands the relative error is also measured. These checks separate a working correction table from a missing or misplaced one: the corrected mean error must be below that of the uncorrected method.

// File: rtl/mitch_pkg.sv
package mitch_pkg;
  // average log-domain error of the plain method over fraction cells (i, j),
  // in units of 1/(2*d*d), d = 2^(idx_w+1)
  function automatic int unsigned corr_calc(int unsigned i, int unsigned j,
                                            int unsigned idx_w);
    int unsigned d, a, b, q, full, t, s;
    d    = 2 << idx_w;
    a    = d + 2 * i + 1;
    b    = d + 2 * j + 1;
    q    = a * b;
    full = 2 * d * d;
    t    = (q < full) ? (2 * q - full) : q;
    s    = 4 * d * (i + j + 1);
    return t - s;
  endfunction
endpackage

// File: rtl/mitch_lod.sv
module mitch_lod #(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 4,
  parameter int FRAC_W = 15
) (
  input  logic [DATA_W-1:0] op_i,
  output logic [CHAR_W-1:0] char_o,
  output logic [FRAC_W-1:0] frac_o
);
  logic [CHAR_W-1:0] sh;

  always_comb begin
    char_o = '0;
    for (int p = 0; p < DATA_W; p++)
      if (op_i[p]) char_o = CHAR_W'(p);
  end

  assign sh     = CHAR_W'(FRAC_W) - char_o;
  assign frac_o = FRAC_W'(op_i << sh);
endmodule

// File: rtl/mitch_corr_rom.sv
module mitch_corr_rom #(
  parameter int IDX_W  = 3,
  parameter int CORR_W = 8
) (
  input  logic [2*IDX_W-1:0] idx_i,
  output logic [CORR_W-1:0]  corr_o
);
  localparam int DEPTH = 1 << (2 * IDX_W);
  localparam int MASK  = (1 << IDX_W) - 1;

  logic [CORR_W-1:0] rom [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_rom
    assign rom[e] = CORR_W'(mitch_pkg::corr_calc(e >> IDX_W, e & MASK, IDX_W));
  end

  assign corr_o = rom[idx_i];
endmodule

// File: rtl/mitch_antilog.sv
module mitch_antilog #(
  parameter int FRAC_W = 15,
  parameter int INT_W  = 6,
  parameter int PROD_W = 32
) (
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [PROD_W-1:0] res_o
);
  localparam int WIDE_W = FRAC_W + 1 + PROD_W;

  logic [WIDE_W-1:0] wide;

  assign wide = WIDE_W'({1'b1, frac_i}) << int_i;

  always_comb begin
    if (int_i >= INT_W'(PROD_W)) res_o = '1;
    else                         res_o = PROD_W'(wide >> FRAC_W);
  end
endmodule

// File: rtl/mitch_log_mult.sv
module mitch_log_mult #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DATA_W-1:0]     op_a_i,
  input  logic [DATA_W-1:0]     op_b_i,
  output logic [2*DATA_W-1:0]   prod_o
);
  localparam int FRAC_W    = DATA_W - 1;
  localparam int CHAR_W    = $clog2(DATA_W);
  localparam int PROD_W    = 2 * DATA_W;
  localparam int INT_W     = $clog2(PROD_W) + 1;
  localparam int CORR_FRAC = 2 * IDX_W + 3;
  localparam int CORR_W    = CORR_FRAC - 1;
  localparam int SUM_W     = FRAC_W + 2;

  logic [DATA_W-1:0] ops   [2];
  logic [CHAR_W-1:0] chars [2];
  logic [FRAC_W-1:0] fracs [2];
  logic [CORR_W-1:0] corr;
  logic [SUM_W-1:0]  frac_sum;
  logic [INT_W-1:0]  int_sum;
  logic [PROD_W-1:0] res;
  logic              zero_op;
  logic [PROD_W-1:0] prod_q;

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_log
    mitch_lod #(.DATA_W(DATA_W), .CHAR_W(CHAR_W), .FRAC_W(FRAC_W)) u_lod (
      .op_i   (ops[g]),
      .char_o (chars[g]),
      .frac_o (fracs[g])
    );
  end

  mitch_corr_rom #(.IDX_W(IDX_W), .CORR_W(CORR_W)) u_rom (
    .idx_i  ({fracs[0][FRAC_W-1 -: IDX_W], fracs[1][FRAC_W-1 -: IDX_W]}),
    .corr_o (corr)
  );

  // correction is aligned from weight 2^-CORR_FRAC onto the fraction grid
  assign frac_sum = SUM_W'(fracs[0]) + SUM_W'(fracs[1])
                  + (SUM_W'(corr) << (FRAC_W - CORR_FRAC));
  assign int_sum  = INT_W'(chars[0]) + INT_W'(chars[1])
                  + INT_W'(frac_sum[SUM_W-1:FRAC_W]);

  mitch_antilog #(.FRAC_W(FRAC_W), .INT_W(INT_W), .PROD_W(PROD_W)) u_alog (
    .int_i  (int_sum),
    .frac_i (frac_sum[FRAC_W-1:0]),
    .res_o  (res)
  );

  assign zero_op = (op_a_i == '0) || (op_b_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prod_q <= '0;
    else if (zero_op) prod_q <= '0;
    else              prod_q <= res;
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/mitch_log_mult_chk.sv
module mitch_log_mult_chk #(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [DATA_W-1:0]   op_a_i,
  input logic [DATA_W-1:0]   op_b_i,
  input logic [2*DATA_W-1:0] prod_o,
  input logic [CHAR_W-1:0]   char_a,
  input logic [CHAR_W-1:0]   char_b
);
  localparam int PROD_W = 2 * DATA_W;

  logic              both_nz;
  logic [CHAR_W:0]   char_sum;
  logic [PROD_W:0]   floor_val;

  assign both_nz   = (op_a_i != '0) && (op_b_i != '0);
  assign char_sum  = (CHAR_W+1)'(char_a) + (CHAR_W+1)'(char_b);
  assign floor_val = (PROD_W+1)'(1) << char_sum;

  AST_CHAR_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_a_i != '0) |-> ((op_a_i >> char_a) == DATA_W'(1))); // R4
  AST_CHAR_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_b_i != '0) |-> ((op_b_i >> char_b) == DATA_W'(1))); // R4
  AST_ZERO_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !both_nz |=> (prod_o == '0)); // R3
  AST_NONZERO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both_nz |=> (prod_o != '0)); // R6
  AST_POW2_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both_nz |=> ({1'b0, prod_o} >= $past(floor_val))); // R6
  AST_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_a_i == '1 && op_b_i == '1) |=> (prod_o == '1)); // R7
endmodule

bind mitch_log_mult mitch_log_mult_chk #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .op_a_i (op_a_i),
  .op_b_i (op_b_i),
  .prod_o (prod_o),
  .char_a (chars[0]),
  .char_b (chars[1])
);

// File: tb/mitch_log_mult_tb_top.sv
`timescale 1ns/1ps
module mitch_log_mult_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] op_a_i = '0;
  logic [15:0] op_b_i = '0;
  logic [31:0] prod_o;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;
  real  sum_err_c = 0.0;
  real  sum_err_m = 0.0;
  int   n_acc = 0;

  always #2.5 clk_i = ~clk_i;

  mitch_log_mult dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_a_i (op_a_i),
    .op_b_i (op_b_i),
    .prod_o (prod_o)
  );

  function automatic int msb_pos(input int unsigned v);
    int r = 0;
    for (int p = 0; p < 16; p++) if (v[p]) r = p;
    return r;
  endfunction

  // R5 formula as stated
  function automatic longint ref_corr(input int i, input int j);
    longint a = 17 + 2 * i;
    longint b = 17 + 2 * j;
    longint q = a * b;
    longint t = (q < 512) ? (2 * q - 512) : q;
    return t - 64 * (i + j + 1);
  endfunction

  function automatic longint unsigned model(input int unsigned a, input int unsigned b);
    int ka, kb, ip;
    longint xa, xb, fs, f;
    if (a == 0 || b == 0) return 0;
    ka = msb_pos(a);
    kb = msb_pos(b);
    xa = longint'(a - (1 << ka)) << (15 - ka);
    xb = longint'(b - (1 << kb)) << (15 - kb);
    fs = xa + xb + (ref_corr(int'(xa >> 12), int'(xb >> 12)) << 6);
    ip = ka + kb + int'(fs >> 15);
    f  = fs & 64'h7FFF;
    if (ip >= 32) return 64'hFFFF_FFFF;
    return ((64'd32768 + f) << ip) >> 15;
  endfunction

  function automatic real plain_mitchell(input int unsigned a, input int unsigned b);
    int  ka = msb_pos(a);
    int  kb = msb_pos(b);
    real s  = real'(a) / real'(longint'(1) << ka) - 1.0
            + real'(b) / real'(longint'(1) << kb) - 1.0;
    real base = real'(longint'(1) << (ka + kb));
    return (s < 1.0) ? base * (1.0 + s) : 2.0 * base * s;
  endfunction

  task automatic check(input string req, input longint unsigned act,
                       input longint unsigned exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on a falling edge, sample at the next falling edge (one register)
  task automatic run_op(input string req, input int unsigned a, input int unsigned b);
    longint unsigned exp;
    real ex, ec, em;
    op_a_i = 16'(a);
    op_b_i = 16'(b);
    @(negedge clk_i);
    exp = model(a, b);
    check(req, 64'(prod_o), exp);
    if (a >= 256 && b >= 256) begin
      ex = real'(longint'(a) * longint'(b));
      ec = (real'(prod_o) - ex) / ex;
      em = (plain_mitchell(a, b) - ex) / ex;
      if (ec < 0.0) ec = -ec;
      if (em < 0.0) em = -em;
      sum_err_c += ec;
      sum_err_m += em;
      n_acc++;
      n_run++;
      if (ec >= 0.06) begin
        n_fail++;
        $display("FAIL R8: rel err actual %f expected below 0.06 (a=%0d b=%0d)", ec, a, b);
      end
    end
  endtask

  initial begin
    int unsigned a, b;
    void'($urandom(32'h5EED_0042));
    op_a_i = 16'd7;
    op_b_i = 16'd9;
    #1;
    repeat (3) @(negedge clk_i);
    check("R1 reset", 64'(prod_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_op("R3 a zero", 0, 16'd1234);
    run_op("R3 b zero", 16'hFFFF, 0);
    run_op("R3 both zero", 0, 0);
    run_op("R6 one by one", 1, 1);
    check("R6 1x1 value", 64'(prod_o), 64'd1);
    run_op("R6 3x3", 3, 3);
    check("R6 3x3 value", 64'(prod_o), 64'd8);
    run_op("R5 pow2", 16'd32768, 16'd32768);
    check("R5 corner corr value", 64'(prod_o), 64'h4040_0000);
    run_op("R4 25x1", 25, 1);
    run_op("R7 saturate", 16'hFFFF, 16'hFFFF);
    check("R7 saturate value", 64'(prod_o), 64'hFFFF_FFFF);
    run_op("R6 max by one", 16'hFFFF, 1);

    // R2: back-to-back operands, each result one cycle after its inputs
    run_op("R2 seq 0", 16'd1000, 16'd3000);
    run_op("R2 seq 1", 16'd50, 16'd60000);
    run_op("R2 seq 2", 16'd0, 16'd60000);
    run_op("R2 seq 3", 16'd40000, 16'd333);

    for (int n = 0; n < 3000; n++) begin
      a = $urandom & ((32'd1 << (1 + $urandom % 16)) - 1);
      b = $urandom & ((32'd1 << (1 + $urandom % 16)) - 1);
      run_op("R5 R6 random", a, b);
    end
    for (int n = 0; n < 2000; n++) begin
      a = 256 + $urandom % 65280;
      b = 256 + $urandom % 65280;
      run_op("R8 random large", a, b);
    end

    n_run++;
    if (sum_err_c / n_acc >= sum_err_m / n_acc) begin
      n_fail++;
      $display("FAIL R8: mean err actual %f expected below %f",
               sum_err_c / n_acc, sum_err_m / n_acc);
    end

    // R1: asynchronous reset clears without a clock edge
    op_a_i = 16'd500;
    op_b_i = 16'd700;
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    check("R1 async clear", 64'(prod_o), 64'd0);
    @(negedge clk_i);
    check("R1 held in reset", 64'(prod_o), 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule